// File: doc/BRIEF.md
# Key press duration classifier

This block watches a single push-button whose contact pulls the input low while it is pressed. It measures how long each press lasts in milliseconds. When the button is let go, it sorts the press into one of three outcomes. A very brief closure is treated as contact noise and reported as nothing. A press held past the noise floor but shorter than a configurable threshold is a short press. Anything held for the threshold or longer is a long press.

The raw input first goes through a two-flop synchronizer. A clock divider produces the millisecond ticks. It is restarted at the start of every press, so the measured time begins at the moment the low level is seen. The elapsed-time counter saturates at the long-press threshold instead of wrapping, so a button held for a very long time still reads as long. Each short or long result is announced by a one-cycle strobe. The 2-bit result code keeps its value until the next strobe.

Top module: `keypress_classifier`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to the released state, `evt_o` is 0 and `code_o` is 2'b00 (no press).
- R2: After release, the elapsed time is the number of whole milliseconds counted while the synchronized key stayed low after the press was detected. One millisecond is CLK_HZ/1000 clock cycles, and the divider restarts at each press. If the raw key is low for H cycles, the elapsed value is (H-1)/(CLK_HZ/1000), rounded down.
- R3: An elapsed time of GLITCH_MS or less produces no strobe and leaves `code_o` unchanged.
- R4: An elapsed time greater than GLITCH_MS and less than LONG_MS reports a short press, code 2'b01.
- R5: An elapsed time of LONG_MS or more reports a long press, code 2'b10. This includes an elapsed time exactly equal to LONG_MS.
- R6: The elapsed counter saturates at LONG_MS and never wraps. A hold many times longer than the threshold is still reported as long.
- R7: `evt_o` is high for exactly one clock cycle per reported short or long press. It is high only while `code_o` shows 2'b01 or 2'b10, and it rises within four cycles of the raw key returning high.
- R8: `code_o` changes only in the cycle in which `evt_o` is high, and otherwise holds the last reported result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_n | input | 1 | Raw button level, 0 while pressed |
| evt_o | output | 1 | One-cycle strobe when a press is classified |
| code_o | output | 2 | Result: 00 none, 01 short, 10 long |

## Verification
Presses are held for lengths placed on both sides of each boundary, so each test separates two outcomes. Holds of 10 and 11 ms tell noise from a short press. Holds one cycle under and exactly at the threshold tell short from long. A hold far beyond the threshold tells a saturating counter from a wrapping one, because a wrapped count would fall back into the short range. Noise presses placed after short and long results show that the held code survives a press that is ignored.

// File: rtl/kpc_pkg.sv
// Shared result encoding and state type for the key press classifier.
package kpc_pkg;
    typedef enum logic [1:0] {
        KPC_NONE  = 2'b00,
        KPC_SHORT = 2'b01,
        KPC_LONG  = 2'b10
    } kpc_code_e;

    typedef enum logic {
        KPC_IDLE  = 1'b0,
        KPC_HELD  = 1'b1
    } kpc_state_e;
endpackage

// File: rtl/kpc_sync2.sv
// Two-flop synchronizer for the raw key level.
// Assumes the input is asynchronous to clk. Reset loads the released level (1).
module kpc_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic meta_q, sync_q;

    // Shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/kpc_ms_tick.sv
// Millisecond tick generator: pulses once every DIV cycles while enabled.
// Assumes DIV >= 2. restart_i clears the phase so counting starts fresh.
module kpc_ms_tick #(
    parameter int DIV = 100_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic en_i,
    output logic tick_o
);
    localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] div_q;

    // Count cycles within the current millisecond.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            div_q <= '0;
        end else if (en_i) begin
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
        end
    end

    assign tick_o = en_i && (div_q == LAST);

    // R2: the phase counter never passes the last count
    p_div_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= LAST);
endmodule

// File: rtl/kpc_press_fsm.sv
// Press tracker and classifier. It arms on a low synchronized key, counts
// ms ticks with saturation at LONG_MS, and classifies on release.
// Assumes GLITCH_MS < LONG_MS and a synchronized key input.
module kpc_press_fsm
    import kpc_pkg::*;
#(
    parameter int LONG_MS   = 1000,
    parameter int GLITCH_MS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_i,
    input  logic       tick_i,
    output logic       restart_o,
    output logic       count_en_o,
    output logic       evt_o,
    output logic [1:0] code_o
);
    localparam int EL_W = $clog2(LONG_MS + 1);
    localparam logic [EL_W-1:0] SAT = EL_W'(LONG_MS);
    localparam logic [EL_W-1:0] FLOOR = EL_W'(GLITCH_MS);

    kpc_state_e     state_q;
    logic [EL_W-1:0] elapsed_q;
    logic           evt_q;
    kpc_code_e      code_q;
    logic           arm, release_seen;
    kpc_code_e      verdict;

    assign arm          = (state_q == KPC_IDLE) && !key_i;
    assign release_seen = (state_q == KPC_HELD) && key_i;
    assign restart_o    = arm;
    assign count_en_o   = (state_q == KPC_HELD) && !key_i;

    // Classify the measured hold time.
    always_comb begin
        if (elapsed_q >= SAT)        verdict = KPC_LONG;
        else if (elapsed_q > FLOOR)  verdict = KPC_SHORT;
        else                         verdict = KPC_NONE;
    end

    // Track released and held states.
    always_ff @(posedge clk) begin
        if (!rst_n)            state_q <= KPC_IDLE;
        else if (arm)          state_q <= KPC_HELD;
        else if (release_seen) state_q <= KPC_IDLE;
    end

    // Saturating millisecond counter for the current press.
    always_ff @(posedge clk) begin
        if (!rst_n || arm)               elapsed_q <= '0;
        else if (tick_i && elapsed_q != SAT) elapsed_q <= elapsed_q + 1'b1;
    end

    // Register the strobe and the held result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q  <= 1'b0;
            code_q <= KPC_NONE;
        end else begin
            evt_q <= release_seen && (verdict != KPC_NONE);
            if (release_seen && verdict != KPC_NONE) code_q <= verdict;
        end
    end

    assign evt_o  = evt_q;
    assign code_o = code_q;

    // R6: elapsed counter never goes past the threshold
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        elapsed_q <= SAT);
    // R6: once saturated it stays put until a new press
    p_sat_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (elapsed_q == SAT && !arm) |=> elapsed_q == SAT);
    // R7: strobe lasts one cycle
    p_evt_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |=> !evt_q);
    // R7: strobe only carries short or long
    p_evt_code_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> (code_q == KPC_SHORT || code_q == KPC_LONG));
    // R7: strobe follows a held press that has just ended
    p_evt_after_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_q) |-> ($past(state_q) == KPC_HELD && state_q == KPC_IDLE));
    // R8: code only moves with the strobe
    p_code_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_q |=> (evt_q || $stable(code_q)));
endmodule

// File: rtl/keypress_classifier.sv
// Top level: synchronizer, ms tick divider and press classifier.
// Assumes CLK_HZ is a multiple of 1000 and at least 2000.
module keypress_classifier
    import kpc_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int LONG_MS   = 1000,
    parameter int GLITCH_MS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_n,
    output logic       evt_o,
    output logic [1:0] code_o
);
    localparam int DIV = CLK_HZ / 1000;

    logic key_s, tick, restart, count_en;

    kpc_sync2 i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (key_n),
        .q_o   (key_s)
    );

    kpc_ms_tick #(.DIV(DIV)) i_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .en_i      (count_en),
        .tick_o    (tick)
    );

    kpc_press_fsm #(.LONG_MS(LONG_MS), .GLITCH_MS(GLITCH_MS)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_i      (key_s),
        .tick_i     (tick),
        .restart_o  (restart),
        .count_en_o (count_en),
        .evt_o      (evt_o),
        .code_o     (code_o)
    );

    // R1: outputs idle in the cycle after a reset edge
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!evt_o && code_o == 2'b00));
endmodule

// File: tb/test_keypress_classifier.sv
module test_keypress_classifier;
    localparam int CLK_HZ = 10_000;
    localparam int DIV    = CLK_HZ / 1000;
    localparam int LONG   = 50;
    localparam int GLITCH = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key_n = 1'b1;
    logic evt_o;
    logic [1:0] code_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [1:0] last_code = 2'b00;

    keypress_classifier #(.CLK_HZ(CLK_HZ), .LONG_MS(LONG), .GLITCH_MS(GLITCH)) i_keypress_classifier (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_n  (key_n),
        .evt_o  (evt_o),
        .code_o (code_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Hold the key low for `hold` cycles, then release and watch the strobe.
    task automatic press(input int hold, input string req);
        int el, nstrobe, seen_code, exp_code;
        el = (hold - 1) / DIV;
        if (el > LONG) el = LONG;
        if (el >= LONG)       exp_code = 2;
        else if (el > GLITCH) exp_code = 1;
        else                  exp_code = 0;
        @(negedge clk) key_n = 1'b0;
        repeat (hold) @(negedge clk);
        key_n = 1'b1;
        nstrobe = 0;
        seen_code = -1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (evt_o) begin
                nstrobe++;
                seen_code = code_o;
                check(i < 4, "R7 strobe latency", i, 3);
            end
        end
        if (exp_code == 0) begin
            check(nstrobe == 0, {req, " R3 no strobe"}, nstrobe, 0);
            check(code_o == last_code, {req, " R8 code held"}, code_o, last_code);
        end else begin
            check(nstrobe == 1, {req, " R7 one strobe"}, nstrobe, 1);
            check(seen_code == exp_code, {req, " code at strobe"}, seen_code, exp_code);
            check(code_o == exp_code, {req, " R8 code after"}, code_o, exp_code);
            last_code = 2'(exp_code);
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(evt_o == 1'b0, "R1 strobe low", evt_o, 0);
        check(code_o == 2'b00, "R1 code none", code_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        last_code = 2'b00;
    endtask

    task automatic t_noise();
        press(3, "R3 tiny glitch");
        press(GLITCH * DIV + 1 + DIV - 1, "R3 floor 10ms");
    endtask

    task automatic t_short();
        press((GLITCH + 1) * DIV + 1, "R4 11ms");
        press(30 * DIV + 5, "R4 30ms R2");
        press(LONG * DIV, "R4 just under");
    endtask

    task automatic t_long();
        press(LONG * DIV + 1, "R5 exact threshold");
        press(5 * DIV, "R3 noise after long");
        press(140 * DIV + 3, "R6 saturate");
        press(20 * DIV, "R4 short after long");
        press(2, "R8 glitch keeps short");
    endtask

    task automatic t_reset_mid();
        press(LONG * DIV + 20, "R5 before reset");
        t_reset();
        press(4, "R1 R8 noise after reset");
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_noise();
        t_short();
        t_long();
        t_reset_mid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule